// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block takes a set of level interrupt requests, each with a programmable priority level, and raises one interrupt line to a single processor. It raises the line only when the best pending request ranks strictly above the priority of the handler that is running now. That running priority sits in a current-priority register. Each accepted interrupt saves the old value on a small priority stack. An end-of-interrupt write restores the saved value from that stack.

There are two ways to accept an interrupt, and a configuration bit selects between them. In software vector mode, the handler reads an acknowledge register to learn which source won. In hardware vector mode, the block drives the winning source number on a vector bus and the processor answers with a one-cycle acknowledge pulse. In both modes the interrupt line drops for at least one clock after each acknowledge. If an acknowledge and an end-of-interrupt write land in the same cycle, the current priority takes the new value and the stack is left untouched.

Top module: `vpic_top`

## Requirements
- R1: Bit 0 of the control register (address 0) selects hardware vector mode when set and software vector mode when clear. The `cpu_vec_en` output equals this bit. The bit resets to 0.
- R2: `cpu_irq` is registered. It goes high one clock after the highest pending priority becomes strictly greater than the current priority. A source with priority 0 never raises it.
- R3: Among pending sources, the one with the higher priority wins. When priorities are equal, the lowest source index wins.
- R4: In software vector mode, reading address 1 while `cpu_irq` is high returns the winning source index in the low bits and acknowledges the interrupt. In this mode `cpu_vec` is all zeros, and `cpu_ack` changes neither `cpu_irq` nor the current priority.
- R5: In hardware vector mode, `cpu_vec` carries the index of the source that `cpu_irq` is raised for, and it updates in the same cycle that `cpu_irq` does. A one-cycle `cpu_ack` pulse while `cpu_irq` is high acknowledges the interrupt.
- R6: After any acknowledge, `cpu_irq` is low in the next cycle, even if a higher-priority request is already pending.
- R7: An acknowledge pushes the current priority onto the stack and loads the current priority with the acknowledged source's priority. The current priority can be read at address 3.
- R8: A write to address 2 (end of interrupt) pops the top of the stack into the current priority.
- R9: If an acknowledge and an end-of-interrupt write occur in the same cycle, the current priority takes the acknowledged priority and the stack is neither pushed nor popped.
- R10: A push onto a full stack discards the oldest entry. A pop from an empty stack loads priority 0.
- R11: The priority of source i is read and written at address 4+i, using the low 4 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW (5) | Register address |
| bus_wdata | input | DW (8) | Write data |
| bus_rdata | output | DW (8) | Read data, valid in the cycle of the read |
| src_req | input | NSRC (8) | Level interrupt requests |
| cpu_irq | output | 1 | Interrupt request to the processor |
| cpu_vec | output | VW (3) | Winning source index (hardware vector mode) |
| cpu_vec_en | output | 1 | High when hardware vector mode is active |
| cpu_ack | input | 1 | Acknowledge pulse from the processor |

## Verification
A wrong current priority shows up within one or two clocks. `cpu_irq` either fails to rise for a request that should preempt, or rises for one that should not, and reading address 3 exposes the value directly. A corrupted stack stays hidden until the end-of-interrupt writes unwind it. The bench therefore drains the stack completely after every nesting sequence and compares each restored level. This catches both a push that was lost and a push that was made twice in the collision case.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  localparam int unsigned REG_CTRL = 0;
  localparam int unsigned REG_ACK  = 1;
  localparam int unsigned REG_EOI  = 2;
  localparam int unsigned REG_CUR  = 3;
  localparam int unsigned REG_PRIO = 4;
endpackage

// File: rtl/vpic_arbiter.sv
module vpic_arbiter #(
  parameter int unsigned NSRC = 8,
  parameter int unsigned PW   = 4,
  localparam int unsigned VW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]         req,
  input  logic [NSRC-1:0][PW-1:0] prio,
  output logic [PW-1:0]           win_pri,
  output logic [VW-1:0]           win_idx
);
  logic [NSRC-1:0][PW-1:0] eff;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_mask
      assign eff[g] = req[g] ? prio[g] : '0;
    end
  endgenerate

  // scan from the top index down; ">=" lets a lower index take ties
  always_comb begin
    win_pri = '0;
    win_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (eff[i] >= win_pri) begin
        win_pri = eff[i];
        win_idx = VW'(i);
      end
    end
  end
endmodule

// File: rtl/vpic_lifo.sv
module vpic_lifo #(
  parameter int unsigned DEPTH = 15,
  parameter int unsigned PW    = 4,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [PW-1:0] din,
  output logic [PW-1:0] top,
  output logic [CW-1:0] cnt
);
  logic [DEPTH-1:0][PW-1:0] stk_q, stk_d;
  logic [CW-1:0]            cnt_d;
  logic                     full;

  assign full = (cnt == CW'(DEPTH));
  assign top  = stk_q[0];

  // entry 0 is the top; a push shifts everything down and the oldest falls off
  always_comb begin
    stk_d = stk_q;
    cnt_d = cnt;
    if (push && !pop) begin
      for (int i = DEPTH - 1; i > 0; i--) stk_d[i] = stk_q[i-1];
      stk_d[0] = din;
      if (!full) cnt_d = cnt + 1'b1;
    end else if (pop && !push) begin
      for (int i = 0; i < DEPTH - 1; i++) stk_d[i] = stk_q[i+1];
      stk_d[DEPTH-1] = '0;
      if (cnt != '0) cnt_d = cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stk_q <= '0;
      cnt   <= '0;
    end else if (push ^ pop) begin
      stk_q <= stk_d;
      cnt   <= cnt_d;
    end
  end

  // R10
  lifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R10
  lifo_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && full) |=> (cnt == CW'(DEPTH)) && (top == $past(din)));
  // R10
  lifo_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && cnt == '0) |=> (top == '0));
endmodule

// File: rtl/vpic_regs.sv
module vpic_regs
  import vpic_pkg::*;
#(
  parameter int unsigned NSRC = 8,
  parameter int unsigned PW   = 4,
  parameter int unsigned AW   = 5,
  parameter int unsigned DW   = 8,
  localparam int unsigned VW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [AW-1:0]           bus_addr,
  input  logic [DW-1:0]           bus_wdata,
  output logic [DW-1:0]           bus_rdata,
  input  logic [VW-1:0]           vec_now,
  input  logic [PW-1:0]           cur_pri,
  output logic                    hw_en,
  output logic [NSRC-1:0][PW-1:0] prio,
  output logic                    ack_rd,
  output logic                    eoi_wr
);
  logic                    hw_en_d;
  logic [NSRC-1:0][PW-1:0] prio_d;
  logic [NSRC-1:0]         prio_sel;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_dec
      assign prio_sel[g] = (bus_addr == AW'(REG_PRIO + g));
    end
  endgenerate

  assign ack_rd = bus_rd && (bus_addr == AW'(REG_ACK));
  assign eoi_wr = bus_wr && (bus_addr == AW'(REG_EOI));

  always_comb begin
    hw_en_d = hw_en;
    prio_d  = prio;
    if (bus_wr) begin
      if (bus_addr == AW'(REG_CTRL)) hw_en_d = bus_wdata[0];
      for (int i = 0; i < NSRC; i++)
        if (prio_sel[i]) prio_d[i] = bus_wdata[PW-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(REG_CTRL)) bus_rdata[0] = hw_en;
    if (bus_addr == AW'(REG_ACK))  bus_rdata[VW-1:0] = vec_now;
    if (bus_addr == AW'(REG_CUR))  bus_rdata[PW-1:0] = cur_pri;
    for (int i = 0; i < NSRC; i++)
      if (prio_sel[i]) bus_rdata[PW-1:0] = prio[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw_en <= 1'b0;
      prio  <= '0;
    end else if (bus_wr) begin
      hw_en <= hw_en_d;
      prio  <= prio_d;
    end
  end
endmodule

// File: rtl/vpic_top.sv
module vpic_top #(
  parameter int unsigned NSRC       = 8,
  parameter int unsigned PW         = 4,
  parameter int unsigned LIFO_DEPTH = 15,
  parameter int unsigned AW         = 5,
  parameter int unsigned DW         = 8,
  localparam int unsigned VW        = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int unsigned CW        = $clog2(LIFO_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] src_req,
  output logic            cpu_irq,
  output logic [VW-1:0]   cpu_vec,
  output logic            cpu_vec_en,
  input  logic            cpu_ack
);
  logic                    rs1_q, rs2_q, rst_s;
  logic                    hw_en, ack_rd, eoi_wr, ack_evt;
  logic [NSRC-1:0][PW-1:0] prio;
  logic [PW-1:0]           win_pri, cur_q, cur_d, apri_q, apri_d, lifo_top;
  logic [VW-1:0]           win_idx, vec_q, vec_d;
  logic                    irq_q, irq_d;
  logic [CW-1:0]           lifo_cnt;

  // reset asserts at once and is released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_s = rs2_q;

  vpic_regs #(.NSRC(NSRC), .PW(PW), .AW(AW), .DW(DW)) i_regs (
    .clk(clk), .rst_n(rst_s), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .vec_now(vec_q), .cur_pri(cur_q), .hw_en(hw_en), .prio(prio),
    .ack_rd(ack_rd), .eoi_wr(eoi_wr)
  );

  vpic_arbiter #(.NSRC(NSRC), .PW(PW)) i_arb (
    .req(src_req), .prio(prio), .win_pri(win_pri), .win_idx(win_idx)
  );

  // a push and a pop in the same cycle cancel out at the stack
  vpic_lifo #(.DEPTH(LIFO_DEPTH), .PW(PW)) i_lifo (
    .clk(clk), .rst_n(rst_s), .push(ack_evt), .pop(eoi_wr),
    .din(cur_q), .top(lifo_top), .cnt(lifo_cnt)
  );

  assign ack_evt = irq_q && (hw_en ? cpu_ack : ack_rd);

  always_comb begin
    irq_d  = ack_evt ? 1'b0 : (win_pri > cur_q);
    vec_d  = irq_d ? win_idx : vec_q;
    apri_d = irq_d ? win_pri : apri_q;
    cur_d  = cur_q;
    if (ack_evt)     cur_d = apri_q;
    else if (eoi_wr) cur_d = lifo_top;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      irq_q  <= 1'b0;
      vec_q  <= '0;
      apri_q <= '0;
      cur_q  <= '0;
    end else begin
      irq_q  <= irq_d;
      vec_q  <= vec_d;
      apri_q <= apri_d;
      if (ack_evt || eoi_wr) cur_q <= cur_d;
    end
  end

  assign cpu_irq    = irq_q;
  assign cpu_vec_en = hw_en;
  assign cpu_vec    = hw_en ? vec_q : '0;

  // R6
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ack_evt |=> !cpu_irq);
  // R7
  ack_load_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (ack_evt && !eoi_wr) |=> (cur_q == $past(apri_q)) && (lifo_top == $past(cur_q)));
  // R9
  collide_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (ack_evt && eoi_wr) |=> (cur_q == $past(apri_q)) && $stable(lifo_cnt) && $stable(lifo_top));
  // R4
  sw_ack_ignore_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (!hw_en && cpu_ack && !ack_rd && !eoi_wr) |=> $stable(cur_q));
  // R2
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(cpu_irq) |-> $past(win_pri > cur_q));
endmodule

// File: tb/test_vpic_top.sv
module test_vpic_top;
  localparam int NSRC = 8;
  localparam int DEPTH = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, cpu_ack = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [NSRC-1:0] src_req = '0;
  logic cpu_irq, cpu_vec_en;
  logic [2:0] cpu_vec;
  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [7:0] rd;

  always #5 clk = ~clk;

  vpic_top #(.NSRC(NSRC), .LIFO_DEPTH(DEPTH)) i_vpic_top (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_req(src_req), .cpu_irq(cpu_irq), .cpu_vec(cpu_vec),
    .cpu_vec_en(cpu_vec_en), .cpu_ack(cpu_ack)
  );

  // {request mask, expected irq, expected vector}; priorities 1,5,5,3,7,0,2,7
  localparam logic [11:0] TBL [8] = '{
    {8'h00, 1'b0, 3'd0}, {8'h01, 1'b1, 3'd0}, {8'h06, 1'b1, 3'd1},
    {8'h0E, 1'b1, 3'd1}, {8'h90, 1'b1, 3'd4}, {8'h20, 1'b0, 3'd0},
    {8'h48, 1'b1, 3'd3}, {8'hFF, 1'b1, 3'd4}};

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rdreg(input int a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = 5'(a);
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic ack_pulse();
    cpu_ack = 1'b1;
    @(negedge clk);
    cpu_ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(3);
    // reset state
    chk("R2 reset irq", int'(cpu_irq), 0);
    chk("R1 reset vec_en", int'(cpu_vec_en), 0);
    rdreg(3, rd); chk("R7 reset cur", int'(rd), 0);

    // R11: program priorities and read one back
    wr(4, 1); wr(5, 5); wr(6, 5); wr(7, 3); wr(8, 7); wr(9, 0); wr(10, 2); wr(11, 7);
    rdreg(8, rd); chk("R11 prio readback", int'(rd), 7);
    wr(0, 1);
    chk("R1 vec_en set", int'(cpu_vec_en), 1);

    // arbitration table, hardware vector mode, current priority 0
    for (int k = 0; k < 8; k++) begin
      src_req = TBL[k][11:4];
      tick(2);
      chk("R2 table irq", int'(cpu_irq), int'(TBL[k][3]));
      if (TBL[k][3]) chk("R3 table vec", int'(cpu_vec), int'(TBL[k][2:0]));
    end
    src_req = '0; tick(2);

    // hardware acknowledge with a preempting request arriving at the same time
    src_req = 8'h02; tick(2);
    chk("R5 vec src1", int'(cpu_vec), 1);
    src_req = 8'h12;
    ack_pulse();
    chk("R6 forced drop", int'(cpu_irq), 0);
    tick(1);
    chk("R5 preempt irq", int'(cpu_irq), 1);
    chk("R5 preempt vec", int'(cpu_vec), 4);
    rdreg(3, rd); chk("R7 cur after ack", int'(rd), 5);
    ack_pulse();
    src_req = '0;
    rdreg(3, rd); chk("R7 cur nested", int'(rd), 7);
    wr(2, 0); rdreg(3, rd); chk("R8 pop to 5", int'(rd), 5);
    wr(2, 0); rdreg(3, rd); chk("R8 pop to 0", int'(rd), 0);
    wr(2, 0); rdreg(3, rd); chk("R10 empty pop", int'(rd), 0);

    // R9: acknowledge and end-of-interrupt in one cycle
    src_req = 8'h40; tick(2); ack_pulse();
    src_req = 8'h02; tick(2); ack_pulse();
    src_req = 8'h10; tick(2);
    chk("R5 vec src4", int'(cpu_vec), 4);
    bus_wr = 1'b1; bus_addr = 5'd2; cpu_ack = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; cpu_ack = 1'b0;
    src_req = '0;
    rdreg(3, rd); chk("R9 cur new", int'(rd), 7);
    wr(2, 0); rdreg(3, rd); chk("R9 stack kept", int'(rd), 2);
    wr(2, 0); rdreg(3, rd); chk("R9 bottom", int'(rd), 0);

    // R10: overfill a depth-4 stack through source 0
    for (int k = 1; k <= 5; k++) begin
      wr(4, k); src_req = 8'h01; tick(2);
      chk("R2 climb irq", int'(cpu_irq), 1);
      ack_pulse();
    end
    src_req = '0;
    rdreg(3, rd); chk("R7 cur top", int'(rd), 5);
    for (int k = 4; k >= 0; k--) begin
      wr(2, 0); rdreg(3, rd); chk("R10 unwind", int'(rd), k);
    end

    // software vector mode
    wr(0, 0);
    chk("R1 vec_en clear", int'(cpu_vec_en), 0);
    src_req = 8'h08; tick(2);
    chk("R4 sw irq", int'(cpu_irq), 1);
    chk("R4 sw vec zero", int'(cpu_vec), 0);
    ack_pulse();
    chk("R4 ack ignored irq", int'(cpu_irq), 1);
    rdreg(3, rd); chk("R4 ack ignored cur", int'(rd), 0);
    rdreg(1, rd); chk("R4 ack read vec", int'(rd), 3);
    chk("R6 sw drop", int'(cpu_irq), 0);
    rdreg(3, rd); chk("R7 sw cur", int'(rd), 3);
    src_req = '0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule